// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block drives a word-wide one-time-programmable memory through the whole burn procedure without help from software. After a start strobe it turns on the raised-supply enable and then the programming-voltage enable. It fetches each source word from a simple request interface and gives every address a single timed program pulse, with no read between the pulses. It then makes a second pass in which each word is read back under programming conditions. A word that mismatches gets one more pulse, followed by a read, until it matches or the retry budget is used up.

When every word has matched, the programming voltage is dropped first and the supply second. The sequencer then reads the whole array at nominal supply and compares it with the source. It reports a single pass or fail. On a fail it also reports the address that failed and the total number of extra pulses spent. Pulse width, setup and hold intervals are given in microseconds and turned into clock-cycle counts from a clock-frequency parameter. One down-counter times every interval.

The device pins are active-low chip enable, output enable and program strobe, plus an address bus and separate data-out and data-in buses with a drive enable. The supply enables only request voltages. They do not regulate them.

Top module: `otp_prog_ctrl`

## Requirements
- R1: While reset is held and after release until start, the chip enable, output enable and program strobe are all high, both voltage enables are low, and done, pass and fail are low.
- R2: The programming-voltage enable is never high while the raised-supply enable is low. It rises at least SETUP_US*CLK_MHZ cycles after the supply enable rises, and it falls at least that many cycles before the supply enable falls.
- R3: Every program strobe low period lasts exactly PULSE_US*CLK_MHZ clock cycles.
- R4: The first pass gives addresses 0 through 2^ADDR_W-1, in ascending order, exactly one pulse each, and output enable stays high until all of those pulses are done.
- R5: Address, data-out, chip enable, output enable, drive enable and programming-voltage enable are unchanged for at least SETUP_US*CLK_MHZ cycles before each strobe falls. Address and data stay driven and unchanged while the strobe is low and for HOLD_US*CLK_MHZ cycles after it rises.
- R6: In the verify pass, a word whose read-back differs from the source receives one further pulse and is read again, up to MAX_RETRY extra pulses. A word that matches after exactly MAX_RETRY extra pulses is accepted. retryTotal counts all extra pulses in the run.
- R7: If a word still differs after MAX_RETRY extra pulses, no further pulse is applied and no further address is processed. Both enables are dropped, fail is raised and failAddr holds that address.
- R8: After the verify pass succeeds, the read-back at nominal supply (both enables low) requests and compares every address from 0 upward. The first mismatch ends it with fail and its address in failAddr. Otherwise pass is raised.
- R9: done rises once the sequence ends. done, pass, fail, failAddr and retryTotal then hold, with both enables low, until the next start.
- R10: The data-out drive enable is never high while output enable is low.
- R11: srcReq is high while a source word is needed, and srcAddr then equals the device address. srcData is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_MHZ MHz |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a burn run (accepted when idle or done) |
| srcReq | output | 1 | Source word wanted |
| srcAddr | output | ADDR_W | Address of the wanted source word |
| srcData | input | DATA_W | Source word for srcAddr |
| devAddr | output | ADDR_W | Device address bus |
| devDout | output | DATA_W | Data driven toward the device |
| devDriveEn | output | 1 | devDout is driven onto the device data bus |
| devDin | input | DATA_W | Data read from the device |
| devCeN | output | 1 | Device chip enable, active low |
| devOeN | output | 1 | Device output enable, active low |
| devPgmN | output | 1 | Device program strobe, active low |
| vccHiEn | output | 1 | Request raised supply |
| vppEn | output | 1 | Request programming voltage |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Finished with every word correct |
| fail | output | 1 | Finished with a failure |
| failAddr | output | ADDR_W | Address that caused the failure |
| retryTotal | output | ADDR_W+$clog2(MAX_RETRY+1) | Extra pulses applied in this run |

## Verification
Several rules are checked on every cycle: the supply ordering, the exact strobe width, the setup stability ahead of each strobe, steady pins while the strobe is low, no drive while outputs are enabled, and both enables low once finished. Only the bench's scenarios can show the rest. These are the first-pass order, the pulse count each word receives, and the exact retry boundary, where a word that needs the full budget passes and one that needs one more fails. The read-back catching a word that changed after the voltages dropped is also shown there. For that, the bench runs a memory model in which each address needs a set number of pulses before it takes its data.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [1:0] {
    CNT_SUPPLY,
    CNT_LOAD,
    CNT_PULSE,
    CNT_HOLD
  } cntSel_t;

  typedef struct packed {
    logic    addrClr;
    logic    addrInc;
    logic    latchData;
    logic    cntLoad;
    cntSel_t cntSel;
    logic    retryClr;
    logic    retryInc;
    logic    runClr;
    logic    failCap;
  } ctrlStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VCC_UP,
    S_VPP_UP,
    S_P1_LOAD,
    S_P1_PULSE,
    S_P1_HOLD,
    S_V_LOAD,
    S_V_CHECK,
    S_R_LOAD,
    S_R_PULSE,
    S_R_HOLD,
    S_VPP_DN,
    S_VCC_DN,
    S_RB_LOAD,
    S_RB_CHECK,
    S_DONE
  } seqState_t;

endpackage

// File: rtl/otp_prog_datapath.sv
module otp_prog_datapath
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CLK_MHZ   = 50,
  parameter int PULSE_US  = 100,
  parameter int SETUP_US  = 2,
  parameter int HOLD_US   = 2,
  parameter int MAX_RETRY = 10,
  localparam int RETRY_W  = $clog2(MAX_RETRY + 1),
  localparam int TOTAL_W  = ADDR_W + RETRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  srcData,
  input  logic [DATA_W-1:0]  devDin,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  dataReg,
  output logic               cntZero,
  output logic               match,
  output logic               lastAddr,
  output logic               retryMax,
  output logic [TOTAL_W-1:0] retryTotal,
  output logic [ADDR_W-1:0]  failAddr
);

  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int HOLD_CYC  = CLK_MHZ * HOLD_US;
  localparam int MAX_CYC   = (PULSE_CYC > SETUP_CYC + 1) ? PULSE_CYC : SETUP_CYC + 1;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   loadVal;
  logic [RETRY_W-1:0] retryCnt;

  // A load stage lasts one cycle longer than the setup time, so the
  // data latched in its first cycle is stable for the full setup window.
  always_comb begin
    unique case (strobe.cntSel)
      CNT_SUPPLY: loadVal = CNT_W'(SETUP_CYC - 1);
      CNT_LOAD:   loadVal = CNT_W'(SETUP_CYC);
      CNT_PULSE:  loadVal = CNT_W'(PULSE_CYC - 1);
      default:    loadVal = CNT_W'(HOLD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (strobe.cntLoad) cnt <= loadVal;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              addr <= '0;
    else if (strobe.addrClr) addr <= '0;
    else if (strobe.addrInc) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dataReg <= '0;
    else if (strobe.latchData) dataReg <= srcData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retryCnt   <= '0;
      retryTotal <= '0;
      failAddr   <= '0;
    end else begin
      if (strobe.retryClr)      retryCnt <= '0;
      else if (strobe.retryInc) retryCnt <= retryCnt + 1'b1;
      if (strobe.runClr)        retryTotal <= '0;
      else if (strobe.retryInc) retryTotal <= retryTotal + 1'b1;
      if (strobe.runClr)        failAddr <= '0;
      else if (strobe.failCap)  failAddr <= addr;
    end
  end

  assign cntZero  = (cnt == '0);
  assign match    = (devDin == dataReg);
  assign lastAddr = (addr == {ADDR_W{1'b1}});
  assign retryMax = (retryCnt == RETRY_W'(MAX_RETRY));

endmodule

// File: rtl/otp_prog_control.sv
module otp_prog_control
  import otp_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cntZero,
  input  logic        match,
  input  logic        lastAddr,
  input  logic        retryMax,
  output ctrlStrobe_t strobe,
  output logic        srcReq,
  output logic        devCeN,
  output logic        devOeN,
  output logic        devPgmN,
  output logic        devDriveEn,
  output logic        vccHiEn,
  output logic        vppEn,
  output logic        done,
  output logic        pass,
  output logic        fail
);

  seqState_t state, nxt;
  logic      failFlag, failSet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      failFlag <= 1'b0;
    end else begin
      state <= nxt;
      if (strobe.runClr) failFlag <= 1'b0;
      else if (failSet)  failFlag <= 1'b1;
    end
  end

  always_comb begin
    nxt     = state;
    strobe  = '0;
    failSet = 1'b0;
    unique case (state)
      S_IDLE, S_DONE: if (start) begin
        nxt = S_VCC_UP;
        strobe.runClr = 1'b1; strobe.retryClr = 1'b1; strobe.addrClr = 1'b1;
        strobe.cntLoad = 1'b1; strobe.cntSel = CNT_SUPPLY;
      end
      S_VCC_UP: if (cntZero) begin
        nxt = S_VPP_UP; strobe.cntLoad = 1'b1; strobe.cntSel = CNT_SUPPLY;
      end
      S_VPP_UP: if (cntZero) begin
        nxt = S_P1_LOAD; strobe.cntLoad = 1'b1; strobe.cntSel = CNT_LOAD;
      end
      S_P1_LOAD, S_R_LOAD: if (cntZero) begin
        nxt = (state == S_P1_LOAD) ? S_P1_PULSE : S_R_PULSE;
        strobe.cntLoad = 1'b1; strobe.cntSel = CNT_PULSE;
      end
      S_P1_PULSE, S_R_PULSE: if (cntZero) begin
        nxt = (state == S_P1_PULSE) ? S_P1_HOLD : S_R_HOLD;
        strobe.cntLoad = 1'b1; strobe.cntSel = CNT_HOLD;
      end
      S_P1_HOLD: if (cntZero) begin
        nxt = lastAddr ? S_V_LOAD : S_P1_LOAD;
        strobe.addrInc = !lastAddr; strobe.addrClr = lastAddr;
        strobe.retryClr = 1'b1;
        strobe.cntLoad = 1'b1; strobe.cntSel = CNT_LOAD;
      end
      S_R_HOLD: if (cntZero) begin
        nxt = S_V_LOAD; strobe.cntLoad = 1'b1; strobe.cntSel = CNT_LOAD;
      end
      S_V_LOAD, S_RB_LOAD: if (cntZero) begin
        nxt = (state == S_V_LOAD) ? S_V_CHECK : S_RB_CHECK;
      end
      S_V_CHECK: begin
        strobe.cntLoad = 1'b1;
        if (match && lastAddr) begin
          nxt = S_VPP_DN; strobe.cntSel = CNT_SUPPLY;
        end else if (match) begin
          nxt = S_V_LOAD; strobe.cntSel = CNT_LOAD;
          strobe.addrInc = 1'b1; strobe.retryClr = 1'b1;
        end else if (retryMax) begin
          nxt = S_VPP_DN; strobe.cntSel = CNT_SUPPLY;
          strobe.failCap = 1'b1; failSet = 1'b1;
        end else begin
          nxt = S_R_LOAD; strobe.cntSel = CNT_LOAD; strobe.retryInc = 1'b1;
        end
      end
      S_VPP_DN: if (cntZero) begin
        nxt = S_VCC_DN; strobe.cntLoad = 1'b1; strobe.cntSel = CNT_SUPPLY;
      end
      S_VCC_DN: if (cntZero) begin
        nxt = failFlag ? S_DONE : S_RB_LOAD;
        strobe.addrClr = 1'b1;
        strobe.cntLoad = 1'b1; strobe.cntSel = CNT_LOAD;
      end
      S_RB_CHECK: begin
        if (!match) begin
          nxt = S_DONE; strobe.failCap = 1'b1; failSet = 1'b1;
        end else if (lastAddr) begin
          nxt = S_DONE;
        end else begin
          nxt = S_RB_LOAD; strobe.addrInc = 1'b1;
          strobe.cntLoad = 1'b1; strobe.cntSel = CNT_LOAD;
        end
      end
      default: nxt = S_IDLE;
    endcase
    strobe.latchData = srcReq;
  end

  always_comb begin
    srcReq     = (state == S_P1_LOAD) || (state == S_V_LOAD) || (state == S_RB_LOAD);
    devCeN     = !(state inside {S_P1_LOAD, S_P1_PULSE, S_P1_HOLD, S_V_LOAD, S_V_CHECK,
                                 S_R_LOAD, S_R_PULSE, S_R_HOLD, S_RB_LOAD, S_RB_CHECK});
    devOeN     = !(state inside {S_V_LOAD, S_V_CHECK, S_RB_LOAD, S_RB_CHECK});
    devPgmN    = !(state inside {S_P1_PULSE, S_R_PULSE});
    devDriveEn = state inside {S_P1_LOAD, S_P1_PULSE, S_P1_HOLD, S_R_LOAD, S_R_PULSE, S_R_HOLD};
    vppEn      = state inside {S_VPP_UP, S_P1_LOAD, S_P1_PULSE, S_P1_HOLD, S_V_LOAD,
                               S_V_CHECK, S_R_LOAD, S_R_PULSE, S_R_HOLD};
    vccHiEn    = vppEn || (state == S_VCC_UP) || (state == S_VPP_DN);
    done       = (state == S_DONE);
    pass       = done && !failFlag;
    fail       = done && failFlag;
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CLK_MHZ   = 50,
  parameter int PULSE_US  = 100,
  parameter int SETUP_US  = 2,
  parameter int HOLD_US   = 2,
  parameter int MAX_RETRY = 10,
  localparam int TOTAL_W  = ADDR_W + $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               srcReq,
  output logic [ADDR_W-1:0]  srcAddr,
  input  logic [DATA_W-1:0]  srcData,
  output logic [ADDR_W-1:0]  devAddr,
  output logic [DATA_W-1:0]  devDout,
  output logic               devDriveEn,
  input  logic [DATA_W-1:0]  devDin,
  output logic               devCeN,
  output logic               devOeN,
  output logic               devPgmN,
  output logic               vccHiEn,
  output logic               vppEn,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic [ADDR_W-1:0]  failAddr,
  output logic [TOTAL_W-1:0] retryTotal
);

  ctrlStrobe_t       strobe;
  logic              cntZero, match, lastAddr, retryMax;
  logic [ADDR_W-1:0] addr;

  otp_prog_control ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cntZero(cntZero), .match(match),
    .lastAddr(lastAddr), .retryMax(retryMax), .strobe(strobe), .srcReq(srcReq),
    .devCeN(devCeN), .devOeN(devOeN), .devPgmN(devPgmN), .devDriveEn(devDriveEn),
    .vccHiEn(vccHiEn), .vppEn(vppEn), .done(done), .pass(pass), .fail(fail)
  );

  otp_prog_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US),
    .SETUP_US(SETUP_US), .HOLD_US(HOLD_US), .MAX_RETRY(MAX_RETRY)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .srcData(srcData), .devDin(devDin),
    .addr(addr), .dataReg(devDout), .cntZero(cntZero), .match(match),
    .lastAddr(lastAddr), .retryMax(retryMax), .retryTotal(retryTotal),
    .failAddr(failAddr)
  );

  assign devAddr = addr;
  assign srcAddr = addr;

endmodule

// File: rtl/otp_prog_chk.sv
module otp_prog_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int TOTAL_W   = 20,
  parameter int PULSE_CYC = 5000,
  parameter int SETUP_CYC = 100
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  devAddr,
  input logic [DATA_W-1:0]  devDout,
  input logic               devDriveEn,
  input logic               devCeN,
  input logic               devOeN,
  input logic               devPgmN,
  input logic               vccHiEn,
  input logic               vppEn,
  input logic               done,
  input logic [ADDR_W-1:0]  failAddr,
  input logic [TOTAL_W-1:0] retryTotal
);

  localparam int LOW_W  = $clog2(PULSE_CYC + 2);
  localparam int STAB_W = $clog2(SETUP_CYC + 2);
  localparam int SIG_W  = ADDR_W + DATA_W + 4;

  logic [LOW_W-1:0]  lowCnt;
  logic [STAB_W-1:0] stableCnt;
  logic [SIG_W-1:0]  sigNow, sigPrev;

  assign sigNow = {devAddr, devDout, devDriveEn, devCeN, devOeN, vppEn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt    <= '0;
      stableCnt <= '0;
      sigPrev   <= '0;
    end else begin
      lowCnt  <= devPgmN ? '0 : lowCnt + 1'b1;
      sigPrev <= sigNow;
      if (sigNow != sigPrev)                   stableCnt <= '0;
      else if (stableCnt != {STAB_W{1'b1}})    stableCnt <= stableCnt + 1'b1;
    end
  end

  // R2
  supply_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vppEn |-> vccHiEn);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devPgmN) |-> (lowCnt == LOW_W'(PULSE_CYC)));

  // R5
  setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devPgmN) |-> (stableCnt >= STAB_W'(SETUP_CYC - 1)));

  // R5
  strobe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!devPgmN && $past(!devPgmN)) |->
      ($stable(devAddr) && $stable(devDout) && devDriveEn && !devCeN && devOeN && vppEn));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    devDriveEn |-> devOeN);

  // R9
  done_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vppEn && !vccHiEn && devPgmN));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(retryTotal) && $stable(failAddr)));

endmodule

bind otp_prog_ctrl otp_prog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOTAL_W(TOTAL_W),
  .PULSE_CYC(CLK_MHZ * PULSE_US), .SETUP_CYC(CLK_MHZ * SETUP_US)
) chk_i (.*);

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW      = 3;
  localparam int NW      = 1 << AW;
  localparam int DW      = 16;
  localparam int CLK_MHZ = 1;
  localparam int PULSE   = 100 * CLK_MHZ;
  localparam int SETUP   = 2 * CLK_MHZ;
  localparam int HOLD    = 2 * CLK_MHZ;
  localparam int MAXR    = 10;
  localparam int TW      = AW + $clog2(MAXR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic srcReq, devDriveEn, devCeN, devOeN, devPgmN, vccHiEn, vppEn, done, pass, fail;
  logic [AW-1:0] srcAddr, devAddr, failAddr;
  logic [DW-1:0] srcData, devDout, devDin;
  logic [TW-1:0] retryTotal;

  always #(CLK_PERIOD / 2) clk = ~clk;

  otp_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(CLK_MHZ), .MAX_RETRY(MAXR)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .srcReq(srcReq), .srcAddr(srcAddr),
    .srcData(srcData), .devAddr(devAddr), .devDout(devDout), .devDriveEn(devDriveEn),
    .devDin(devDin), .devCeN(devCeN), .devOeN(devOeN), .devPgmN(devPgmN),
    .vccHiEn(vccHiEn), .vppEn(vppEn), .done(done), .pass(pass), .fail(fail),
    .failAddr(failAddr), .retryTotal(retryTotal)
  );

  // Source image and device model
  function automatic logic [DW-1:0] srcWord(int a);
    return 16'hA5C3 ^ DW'(a * 16'h1111);
  endfunction

  assign srcData = srcWord(int'(srcAddr));

  logic [DW-1:0] mem [NW];
  int need [NW];
  int pulses [NW];
  int order [NW];
  int totalPulses, corruptAt;
  int setupViol, widthViol, holdViol, earlyRead, orderViol, contention, reqViol;
  int rbReads, cyc, vccRise, vppRise, vppFall, vccFall;
  int stab, lowCnt, holdLeft;
  logic prevPgm, prevVcc, prevVpp, prevReq;
  logic [AW+DW+4-1:0] prevSig;
  logic [DW-1:0] holdData;
  logic [AW-1:0] holdAddr;

  assign devDin = mem[devAddr];

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset(input int corrupt);
    for (int a = 0; a < NW; a++) begin
      mem[a] = '1; pulses[a] = 0; order[a] = -1;
    end
    totalPulses = 0; corruptAt = corrupt;
    setupViol = 0; widthViol = 0; holdViol = 0; earlyRead = 0; orderViol = 0;
    contention = 0; reqViol = 0; rbReads = 0; cyc = 0;
    vccRise = -1; vppRise = -1; vppFall = -1; vccFall = -1;
    stab = 0; lowCnt = 0; holdLeft = 0;
  endtask

  always @(negedge clk) begin
    logic [AW+DW+4-1:0] sig;
    if (rst_n) begin
      cyc++;
      sig = {devAddr, devDout, devDriveEn, devCeN, devOeN, vppEn};
      if (sig != prevSig) stab = 0; else stab++;
      prevSig = sig;
      if (prevPgm && !devPgmN) begin
        if (stab < SETUP) setupViol++;
        lowCnt = 0;
      end
      if (!devPgmN) lowCnt++;
      if (!prevPgm && devPgmN) begin
        if (lowCnt != PULSE) widthViol++;
        if (!devCeN && devOeN && vppEn && vccHiEn && devDriveEn) begin
          if (totalPulses < NW) order[totalPulses] = int'(devAddr);
          totalPulses++;
          pulses[devAddr]++;
          if (pulses[devAddr] >= need[devAddr]) mem[devAddr] = mem[devAddr] & devDout;
        end
        holdLeft = HOLD - 1; holdData = devDout; holdAddr = devAddr;
      end else if (holdLeft > 0) begin
        if (devDout != holdData || devAddr != holdAddr || !devDriveEn) holdViol++;
        holdLeft--;
      end
      if (!devCeN && !devOeN && totalPulses < NW) earlyRead++;
      if (vppEn && !vccHiEn) orderViol++;
      if (devDriveEn && !devOeN) contention++;
      if (srcReq && srcAddr != devAddr) reqViol++;
      if (vccHiEn && !prevVcc) vccRise = cyc;
      if (!vccHiEn && prevVcc) vccFall = cyc;
      if (vppEn && !prevVpp) vppRise = cyc;
      if (!vppEn && prevVpp) begin
        vppFall = cyc;
        if (corruptAt >= 0) mem[corruptAt] = mem[corruptAt] ^ 16'h0004;
      end
      if (srcReq && !prevReq && !vccHiEn) rbReads++;
      prevPgm = devPgmN; prevVcc = vccHiEn; prevVpp = vppEn; prevReq = srcReq;
    end else begin
      prevPgm = 1'b1; prevVcc = 1'b0; prevVpp = 1'b0; prevReq = 1'b0; prevSig = '0;
    end
  end

  task automatic runCase(input string tag, input int corrupt);
    int failAt, expTotal, expRb, waitCyc;
    bit expPass;
    logic [AW-1:0] expFailAddr;
    failAt = -1; expTotal = 0;
    for (int a = 0; a < NW; a++) begin
      if (failAt < 0) begin
        if (need[a] - 1 > MAXR) begin expTotal += MAXR; failAt = a; end
        else expTotal += need[a] - 1;
      end
    end
    expPass = (failAt < 0) && (corrupt < 0);
    expFailAddr = (failAt >= 0) ? AW'(failAt) : AW'(corrupt);
    expRb = (failAt >= 0) ? 0 : ((corrupt >= 0) ? corrupt + 1 : NW);

    modelReset(corrupt);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 40000) begin @(negedge clk); waitCyc++; end
    $display("case %s: %0d cycles", tag, waitCyc);
    chk(done === 1'b1, "R9", {tag, " watchdog/done"}, done, 1);

    chk(pass === expPass, "R8", {tag, " pass"}, pass, expPass);
    chk(fail === !expPass, "R7", {tag, " fail"}, fail, !expPass);
    if (!expPass) chk(failAddr == expFailAddr, "R7", {tag, " failAddr"}, failAddr, expFailAddr);
    chk(retryTotal == TW'(expTotal), "R6", {tag, " retryTotal"}, retryTotal, expTotal);
    for (int a = 0; a < NW; a++) begin
      int e;
      e = (failAt < 0 || a < failAt) ? need[a] : ((a == failAt) ? MAXR + 1 : 1);
      chk(pulses[a] == e, "R6", {tag, $sformatf(" pulses@%0d", a)}, pulses[a], e);
    end
    for (int i = 0; i < NW; i++)
      chk(order[i] == i, "R4", {tag, " first-pass order"}, order[i], i);
    chk(earlyRead == 0, "R4", {tag, " read during first pass"}, earlyRead, 0);
    chk(widthViol == 0, "R3", {tag, " pulse width"}, widthViol, 0);
    chk(setupViol == 0, "R5", {tag, " setup"}, setupViol, 0);
    chk(holdViol == 0, "R5", {tag, " hold"}, holdViol, 0);
    chk(orderViol == 0, "R2", {tag, " vpp without vcc"}, orderViol, 0);
    chk(vppRise - vccRise >= SETUP, "R2", {tag, " vpp rise delay"}, vppRise - vccRise, SETUP);
    chk(vccFall - vppFall >= SETUP, "R2", {tag, " vcc fall delay"}, vccFall - vppFall, SETUP);
    chk(contention == 0, "R10", {tag, " drive with oe low"}, contention, 0);
    chk(reqViol == 0, "R11", {tag, " srcAddr"}, reqViol, 0);
    chk(rbReads == expRb, "R8", {tag, " read-back words"}, rbReads, expRb);
    repeat (20) @(negedge clk);
    chk(done && (pass === expPass) && !vppEn && !vccHiEn, "R9", {tag, " held"}, done, 1);
    chk(retryTotal == TW'(expTotal), "R9", {tag, " retryTotal held"}, retryTotal, expTotal);
  endtask

  initial begin
    for (int a = 0; a < NW; a++) need[a] = 1;
    modelReset(-1);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(devCeN && devOeN && devPgmN && !vccHiEn && !vppEn && !done && !pass && !fail,
        "R1", "reset state", {devCeN, devOeN, devPgmN, vccHiEn, vppEn, done}, 6'b111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(devCeN && devOeN && devPgmN && !vccHiEn && !vppEn && !done && !pass && !fail,
        "R1", "idle after reset", {devCeN, devOeN, devPgmN, vccHiEn, vppEn, done}, 6'b111000);

    runCase("clean", -1);

    for (int a = 0; a < NW; a++) need[a] = (a % 4) + 1;
    runCase("mixed", -1);

    for (int a = 0; a < NW; a++) need[a] = 1;
    need[5] = MAXR + 1;
    runCase("edge-retry", -1);

    for (int a = 0; a < NW; a++) need[a] = (a % 2) + 1;
    need[3] = MAXR + 2;
    runCase("over-retry", -1);

    for (int a = 0; a < NW; a++) need[a] = 1;
    runCase("readback", 6);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    nChecks++; nFails++;
    $display("FAIL R9 global watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule